// File: doc/BRIEF.md
# Operand-resolving 15-bit ALU

This block is the combinational execute stage of a small 16-bit word machine whose operands describe themselves. The core hands it one opcode word and three raw operand words. The first operand names the destination register. The second and third are sources. Each source word is either a literal value or a reference to one of eight registers. The unit decides which, reads referenced registers through two read ports that the core's register file serves, computes the result, and returns the result, the destination index, a write strobe and an illegal flag. All of this happens in the same cycle.

All values live in 15 bits, and arithmetic wraps at 32768. The core keeps the register storage, the sequencing and all memory traffic. Opcodes that are not arithmetic, compare or bitwise operations pass through this unit quietly, and the core handles them elsewhere.

Top module: `alu15_unit`

## Requirements
- R1: A source word from 0 to 32767 is used as a literal value, equal to its low 15 bits.
- R2: A source word from 32768 to 32775 selects register (word − 32768). Read port 0 carries the low 3 bits of the second operand word as its index. Read port 1 carries the low 3 bits of the third operand word. The returned port data is used as the value.
- R3: The destination word must lie in 32768..32775, and `dst_idx` equals its low 3 bits. Any other destination raises `illegal` and blocks `wr_en` for a compute opcode.
- R4: A source word of 32776 or more raises `illegal` and blocks the write. Opcode 14 uses only the second word, so an out-of-range third word has no effect on it.
- R5: Opcode 4 writes 1 when the two sources are equal and 0 otherwise. Opcode 5 writes 1 when the first source is greater than the second (unsigned) and 0 otherwise.
- R6: Opcode 9 writes (first + second) mod 32768. Opcode 10 writes (first × second) mod 32768.
- R7: Opcode 11 writes the remainder of the first source divided by the second. A zero divisor raises `illegal` and blocks the write.
- R8: Opcode 12 writes the bitwise AND of the sources. Opcode 13 writes their bitwise OR.
- R9: Opcode 14 writes the bitwise inverse of its source, kept to 15 bits.
- R10: `wr_en` is 1 only for opcodes 4, 5 and 9 to 14 with no illegal condition. For every other opcode, `wr_en` and `illegal` are both 0, whatever the operand words are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 16 | Opcode word of the instruction |
| opnd_a | input | 16 | Raw destination operand word |
| opnd_b | input | 16 | Raw first source operand word |
| opnd_c | input | 16 | Raw second source operand word |
| rd0_idx | output | 3 | Register index for read port 0 (first source) |
| rd0_data | input | 15 | Register value returned on read port 0 |
| rd1_idx | output | 3 | Register index for read port 1 (second source) |
| rd1_data | input | 15 | Register value returned on read port 1 |
| result | output | 15 | Computed value to write |
| dst_idx | output | 3 | Destination register index |
| wr_en | output | 1 | Register write strobe |
| illegal | output | 1 | Operand or divisor fault for a compute opcode |

## Verification
The bench targets the edges of the operand classes: 32767 must stay a literal, 32775 must be the last register, and 32776 must be invalid. A design with an off-by-one range check would either read a register for a literal or accept a word with no register behind it. It also drives sums and products that wrap past 32768, and a NOT whose 16th bit must stay clear. An untruncated datapath would show a result of 32768 or more, or a wrong low word. Further cases cover a zero divisor held in a register, a bad third word on the single-source NOT, and non-compute opcodes with garbage operands. These catch a design that divides blindly, faults on a word it never reads, or raises flags for instructions outside its scope.

// File: rtl/alu15_pkg.sv
// Package: shared opcode values and the internal function select of the
// 15-bit operand-resolving ALU. Assumes opcodes arrive as a full word.
package alu15_pkg;

    localparam int OPC_EQ  = 4;
    localparam int OPC_GT  = 5;
    localparam int OPC_ADD = 9;
    localparam int OPC_MUL = 10;
    localparam int OPC_MOD = 11;
    localparam int OPC_AND = 12;
    localparam int OPC_OR  = 13;
    localparam int OPC_NOT = 14;

    typedef enum logic [3:0] {
        FN_NONE,
        FN_EQ,
        FN_GT,
        FN_ADD,
        FN_MUL,
        FN_MOD,
        FN_AND,
        FN_OR,
        FN_NOT
    } alu_fn_e;

endpackage

// File: rtl/alu15_opnd_res.sv
// Module: alu15_opnd_res
// Classifies one raw source word as a literal, a register reference or an
// invalid word, and yields its value. Assumes the register file answers the
// index combinationally on reg_val.
module alu15_opnd_res #(
    parameter int WORD_W = 16,
    parameter int NREG   = 8,
    localparam int VAL_W = WORD_W - 1,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [WORD_W-1:0] raw,
    input  logic [VAL_W-1:0]  reg_val,
    output logic [IDX_W-1:0]  idx,
    output logic [VAL_W-1:0]  value,
    output logic              is_bad
);
    localparam logic [WORD_W-1:0] REG_BASE = {1'b1, {VAL_W{1'b0}}};
    localparam logic [WORD_W-1:0] REG_END  = REG_BASE + WORD_W'(NREG);

    logic is_lit;
    logic is_reg;

    // Sort the word into one of the three operand classes.
    always_comb begin
        is_lit = (raw < REG_BASE);
        is_reg = (raw >= REG_BASE) && (raw < REG_END);
        is_bad = (raw >= REG_END);
    end

    // Pick the literal or the register value and expose the read index.
    always_comb begin
        idx   = raw[IDX_W-1:0];
        value = is_reg ? reg_val : raw[VAL_W-1:0];
    end

    // Exactly one class holds for every word.
    always_comb begin
        assert_class_onehot_R2: assert ($onehot({is_lit, is_reg, is_bad}))
            else $error("operand class not unique for %0d", raw);
    end

endmodule

// File: rtl/alu15_fn_decode.sv
// Module: alu15_fn_decode
// Maps the opcode word to an internal function select and reports whether
// the third operand word is consumed. Non-compute opcodes map to FN_NONE.
module alu15_fn_decode
    import alu15_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] op_code,
    output alu_fn_e           fn,
    output logic              uses_c
);
    // Opcode lookup.
    always_comb begin
        case (op_code)
            WORD_W'(OPC_EQ):  fn = FN_EQ;
            WORD_W'(OPC_GT):  fn = FN_GT;
            WORD_W'(OPC_ADD): fn = FN_ADD;
            WORD_W'(OPC_MUL): fn = FN_MUL;
            WORD_W'(OPC_MOD): fn = FN_MOD;
            WORD_W'(OPC_AND): fn = FN_AND;
            WORD_W'(OPC_OR):  fn = FN_OR;
            WORD_W'(OPC_NOT): fn = FN_NOT;
            default:          fn = FN_NONE;
        endcase
    end

    // Single-source inverse leaves the third word unread.
    always_comb begin
        uses_c = (fn != FN_NONE) && (fn != FN_NOT);
    end

endmodule

// File: rtl/alu15_exec.sv
// Module: alu15_exec
// Computes the 15-bit result for the selected function. Arithmetic wraps by
// truncation to VAL_W bits. A zero divisor under FN_MOD is reported and
// gives a zero result.
module alu15_exec
    import alu15_pkg::*;
#(
    parameter int VAL_W = 15
) (
    input  alu_fn_e          fn,
    input  logic [VAL_W-1:0] x,
    input  logic [VAL_W-1:0] y,
    output logic [VAL_W-1:0] res,
    output logic             div_zero
);
    logic [VAL_W-1:0] sum_w;
    logic [VAL_W-1:0] prod_w;
    logic [VAL_W-1:0] rem_w;

    // Wrapping arithmetic datapaths.
    always_comb begin
        sum_w  = x + y;
        prod_w = x * y;
        rem_w  = (y == '0) ? '0 : (x % y);
    end

    // Result select by function.
    always_comb begin
        case (fn)
            FN_EQ:   res = {{(VAL_W-1){1'b0}}, (x == y)};
            FN_GT:   res = {{(VAL_W-1){1'b0}}, (x > y)};
            FN_ADD:  res = sum_w;
            FN_MUL:  res = prod_w;
            FN_MOD:  res = rem_w;
            FN_AND:  res = x & y;
            FN_OR:   res = x | y;
            FN_NOT:  res = ~x;
            default: res = '0;
        endcase
    end

    // Flag a remainder request with nothing to divide by.
    always_comb begin
        div_zero = (fn == FN_MOD) && (y == '0);
    end

    // An inverse never shares a set bit with its source.
    always_comb begin
        if (fn == FN_NOT)
            assert_not_disjoint_R9: assert ((res & x) == '0)
                else $error("inverse overlaps source");
    end

endmodule

// File: rtl/alu15_unit.sv
// Module: alu15_unit (top)
// Resolves the two source operands through the register read ports,
// validates the destination, executes the compute opcodes and gates the
// write strobe. Purely combinational; assumes register reads answer in the
// same cycle.
module alu15_unit
    import alu15_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NREG   = 8,
    localparam int VAL_W = WORD_W - 1,
    localparam int IDX_W = $clog2(NREG),
    localparam int NSRC  = 2
) (
    input  logic [WORD_W-1:0] op_code,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] opnd_c,
    output logic [IDX_W-1:0]  rd0_idx,
    input  logic [VAL_W-1:0]  rd0_data,
    output logic [IDX_W-1:0]  rd1_idx,
    input  logic [VAL_W-1:0]  rd1_data,
    output logic [VAL_W-1:0]  result,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              wr_en,
    output logic              illegal
);
    localparam logic [WORD_W-1:0] REG_BASE = {1'b1, {VAL_W{1'b0}}};
    localparam logic [WORD_W-1:0] REG_END  = REG_BASE + WORD_W'(NREG);

    logic [WORD_W-1:0] src_raw [NSRC];
    logic [VAL_W-1:0]  src_rd  [NSRC];
    logic [IDX_W-1:0]  src_idx [NSRC];
    logic [VAL_W-1:0]  src_val [NSRC];
    logic              src_bad [NSRC];

    alu_fn_e fn;
    logic    uses_c;
    logic    dst_ok;
    logic    div_zero;
    logic    fault;

    // Route operand words and read data into the per-source arrays.
    always_comb begin
        src_raw[0] = opnd_b;
        src_raw[1] = opnd_c;
        src_rd[0]  = rd0_data;
        src_rd[1]  = rd1_data;
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            alu15_opnd_res #(
                .WORD_W (WORD_W),
                .NREG   (NREG)
            ) u_res (
                .raw     (src_raw[s]),
                .reg_val (src_rd[s]),
                .idx     (src_idx[s]),
                .value   (src_val[s]),
                .is_bad  (src_bad[s])
            );
        end
    endgenerate

    // Drive read port indices.
    always_comb begin
        rd0_idx = src_idx[0];
        rd1_idx = src_idx[1];
    end

    alu15_fn_decode #(
        .WORD_W (WORD_W)
    ) u_dec (
        .op_code (op_code),
        .fn      (fn),
        .uses_c  (uses_c)
    );

    alu15_exec #(
        .VAL_W (VAL_W)
    ) u_exec (
        .fn       (fn),
        .x        (src_val[0]),
        .y        (src_val[1]),
        .res      (result),
        .div_zero (div_zero)
    );

    // Destination must name a register.
    always_comb begin
        dst_ok  = (opnd_a >= REG_BASE) && (opnd_a < REG_END);
        dst_idx = opnd_a[IDX_W-1:0];
    end

    // Gather faults of a compute opcode and gate the write.
    always_comb begin
        fault   = !dst_ok || src_bad[0] || (uses_c && src_bad[1]) || div_zero;
        illegal = (fn != FN_NONE) && fault;
        wr_en   = (fn != FN_NONE) && !fault;
    end

    // Output consistency checks.
    always_comb begin
        if (wr_en)
            assert_dst_match_R3: assert ((opnd_a >= REG_BASE) && (opnd_a < REG_END)
                                         && (dst_idx == opnd_a[IDX_W-1:0]))
                else $error("write to a non-register destination");
        if (wr_en && ((op_code == WORD_W'(OPC_EQ)) || (op_code == WORD_W'(OPC_GT))))
            assert_bool_result_R5: assert (result <= VAL_W'(1))
                else $error("compare result not 0 or 1");
        if ((op_code == WORD_W'(OPC_MOD)) && (src_val[1] == '0))
            assert_zero_divisor_R7: assert (!wr_en && illegal)
                else $error("zero divisor not faulted");
        if (fn == FN_NONE)
            assert_quiet_other_R10: assert (!wr_en && !illegal)
                else $error("non-compute opcode raised outputs");
    end

endmodule

// File: tb/alu15_unit_tb.sv
// Directed bench for alu15_unit with a behavioural register file.
module alu15_unit_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [15:0] op_code, opnd_a, opnd_b, opnd_c;
    logic [2:0]  rd0_idx, rd1_idx, dst_idx;
    logic [14:0] rd0_data, rd1_data, result;
    logic        wr_en, illegal;

    logic [14:0] regs [8];
    assign rd0_data = regs[rd0_idx];
    assign rd1_data = regs[rd1_idx];

    int n_chk  = 0;
    int n_fail = 0;

    alu15_unit dut_i (
        .op_code  (op_code),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .opnd_c   (opnd_c),
        .rd0_idx  (rd0_idx),
        .rd0_data (rd0_data),
        .rd1_idx  (rd1_idx),
        .rd1_data (rd1_data),
        .result   (result),
        .dst_idx  (dst_idx),
        .wr_en    (wr_en),
        .illegal  (illegal)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic apply(input int op, input int a, input int b, input int c);
        @(negedge clk);
        op_code = 16'(op);
        opnd_a  = 16'(a);
        opnd_b  = 16'(b);
        opnd_c  = 16'(c);
        #2;
    endtask

    task automatic expect_write(input string tag, input int idx, input int val);
        check(tag, "wr_en", int'(wr_en), 1);
        check(tag, "illegal", int'(illegal), 0);
        check(tag, "dst_idx", int'(dst_idx), idx);
        check(tag, "result", int'(result), val);
    endtask

    task automatic expect_fault(input string tag);
        check(tag, "wr_en", int'(wr_en), 0);
        check(tag, "illegal", int'(illegal), 1);
    endtask

    task automatic t_idle();
        apply(0, 0, 0, 0);
        check("R10", "idle wr_en", int'(wr_en), 0);
        check("R10", "idle illegal", int'(illegal), 0);
    endtask

    task automatic t_literal_r1();
        apply(9, 32769, 10, 20);
        expect_write("R1", 1, 30);
        apply(12, 32774, 32767, 32767);
        expect_write("R1", 6, 32767);
    endtask

    task automatic t_register_r2();
        apply(9, 32770, 32768, 32771);
        check("R2", "rd0_idx", int'(rd0_idx), 0);
        check("R2", "rd1_idx", int'(rd1_idx), 3);
        expect_write("R2", 2, 105);
        apply(9, 32775, 32775, 32772);
        expect_write("R2", 7, 10);
    endtask

    task automatic t_dest_r3();
        apply(9, 5, 1, 2);
        expect_fault("R3");
        apply(9, 32776, 1, 2);
        expect_fault("R3");
        apply(9, 32767, 1, 2);
        expect_fault("R3");
    endtask

    task automatic t_bad_src_r4();
        apply(12, 32768, 32776, 1);
        expect_fault("R4");
        apply(13, 32768, 1, 65535);
        expect_fault("R4");
        apply(14, 32771, 0, 40000);
        expect_write("R4", 3, 32767);
    endtask

    task automatic t_compare_r5();
        apply(4, 32768, 7, 32775);
        expect_write("R5", 0, 1);
        apply(4, 32768, 7, 8);
        expect_write("R5", 0, 0);
        apply(5, 32769, 9, 8);
        expect_write("R5", 1, 1);
        apply(5, 32769, 8, 9);
        expect_write("R5", 1, 0);
        apply(5, 32769, 8, 8);
        expect_write("R5", 1, 0);
    endtask

    task automatic t_arith_r6();
        apply(9, 32768, 32767, 32769);
        expect_write("R6", 0, 32766);
        apply(10, 32768, 300, 200);
        expect_write("R6", 0, 27232);
        apply(10, 32768, 32769, 2);
        expect_write("R6", 0, 32766);
    endtask

    task automatic t_mod_r7();
        apply(11, 32772, 100, 7);
        expect_write("R7", 4, 2);
        apply(11, 32772, 5, 32770);
        expect_fault("R7");
        apply(11, 32772, 5, 0);
        expect_fault("R7");
    endtask

    task automatic t_bitwise_r8();
        apply(12, 32773, 32773, 16'h0FF0);
        expect_write("R8", 5, 16'h0550);
        apply(13, 32773, 32773, 32774);
        expect_write("R8", 5, 16'h7FFF);
    endtask

    task automatic t_not_r9();
        apply(14, 32768, 0, 0);
        expect_write("R9", 0, 16'h7FFF);
        apply(14, 32768, 32773, 0);
        expect_write("R9", 0, 16'h2AAA);
    endtask

    task automatic t_other_r10();
        apply(6, 5, 40000, 65535);
        check("R10", "jump wr_en", int'(wr_en), 0);
        check("R10", "jump illegal", int'(illegal), 0);
        apply(22, 1, 2, 3);
        check("R10", "unknown wr_en", int'(wr_en), 0);
        check("R10", "unknown illegal", int'(illegal), 0);
        apply(15, 32768, 32769, 0);
        check("R10", "other wr_en", int'(wr_en), 0);
        check("R10", "other illegal", int'(illegal), 0);
    endtask

    initial begin
        regs[0] = 15'd5;
        regs[1] = 15'd32767;
        regs[2] = 15'd0;
        regs[3] = 15'd100;
        regs[4] = 15'd3;
        regs[5] = 15'h5555;
        regs[6] = 15'h2AAA;
        regs[7] = 15'd7;
        op_code = '0;
        opnd_a  = '0;
        opnd_b  = '0;
        opnd_c  = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_literal_r1();
        t_register_r2();
        t_dest_r3();
        t_bad_src_r4();
        t_compare_r5();
        t_arith_r6();
        t_mod_r7();
        t_bitwise_r8();
        t_not_r9();
        t_other_r10();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule